// File: doc/BRIEF.md
# SPI NOR Operation Sequencer

This block runs one serial NOR flash transaction at a time on one of two chip selects. Software programs an 8-bit opcode, a flash address, a dummy length, a data byte count, a lane mode and a set of phase enables through a small valid/ready register port. It then sets a start bit. The engine lowers the chosen chip select and waits out a programmable setup time. It then clocks out the enabled phases in a fixed order and waits out a programmable hold time. Finally it keeps the chip select high for a programmable deselect time and raises a completion flag.

Write data comes from a local byte buffer and read data goes into the same buffer, starting at byte 0 in both cases. Software reaches the buffer through the register port. The serial clock runs at half the controller clock and idles low. Output bits change after the falling edge, most significant bit first. Input bits are captured on the rising edge. Each lane mode places the address and data phases on one, two or four lanes, and the command phase always uses one lane.

Register word addresses: 0x00 control, 0x01 opcode, 0x02 address, 0x03 configuration, 0x04 byte count, 0x05 timing, 0x06 status. The buffer is at 0x80 plus the byte index.

Top module: `spi_op_seq`

## Requirements
- R1: After reset both cs_n bits are 1, sclk is 0 and io_oe is 0. The status register reads 0. The timing register reads 0x66F.
- R2: Control register bits: bit 7 enables the command phase, bit 6 the address phase, bit 8 the dummy phase, bit 5 a data write, bit 2 a data read and bit 1 a status read (handled as a data read). Writing bit 0 as 1 starts the operation. Phases run as command, then address, then dummy, then data. A disabled phase takes no clocks. When both a write and a read are enabled, the write is performed.
- R3: The command phase is 8 sclk cycles on io_out[0], MSB first, with io_oe = 4'b0001.
- R4: Configuration bit 7 = 0 sends the low 24 bits of the address register. Bit 7 = 1 sends all 32 bits. Both are sent MSB first.
- R5: Configuration bits [6:4] select the lane mode. Mode 0 uses one lane everywhere. Mode 1 puts the data phase on 2 lanes. Mode 2 puts address and data on 2 lanes. Mode 3 puts the data phase on 4 lanes. Mode 4 puts address and data on 4 lanes. Modes 5 to 7 act as mode 0. A single lane sends on io_out[0] and receives on io_in[1]. Two lanes use io[1:0] and four lanes use io[3:0], with the highest lane carrying the earliest bit.
- R6: The dummy phase lasts configuration[3:0] × 8 sclk cycles with io_oe = 0. A count of 0 skips the phase.
- R7: Write data is sent from buffer bytes 0, 1, and so on. Read data, captured at sclk rising edges, is stored into buffer bytes 0, 1, and so on. A byte count of 0 skips the data phase and leaves the buffer unchanged.
- R8: The timing register has hold time in bits [11:8], setup time in bits [7:4] and deselect time in bits [3:0], all in controller clocks. Chip select is low at least the setup time before the first sclk rise. It stays low at least the hold time after the last sclk fall. It is then high at least the deselect time before completion.
- R9: Status bit 0 is set when an operation finishes, after the deselect time. Writing 1 to status bit 0 clears it.
- R10: While status bit 1 (busy) is set, writes to the control, opcode, address, configuration, count, timing and buffer locations have no effect, and a start request is lost.
- R11: Configuration bit 8 selects cs_n[1], otherwise cs_n[0]. At most one chip select is low at a time. sclk is 0 whenever both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted (always 1) |
| reg_rdata | output | 32 | Read data for reg_addr |
| sclk | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The hardest situation to bring about from the ports is a register write or a second start that arrives while an operation is still in flight. Software sees the engine only through polling, so a normal flow never does this. The bench issues an opcode rewrite, a buffer write and a fresh start a few clocks after a long read begins, while the engine is still in its setup wait. After completion it confirms the old opcode on the wire and in the register, the captured byte in the buffer, and no further chip-select activity. Read data comes from a flash model that derives each lane value from the index of the coming rising edge. This lets every mode's received bytes be predicted without knowledge of the engine's internals.

// File: rtl/spi_op_seq.sv
module spi_op_seq #(
  parameter int BUF_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        reg_ready,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic [1:0]  cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int BW = $clog2(BUF_BYTES);

  typedef enum logic [2:0] {IDLE, SETUP, CMD, ADR, DUM, DAT, HOLD, DESEL} st_t;

  st_t         st, nxt;
  logic [8:0]  ctl;
  logic [7:0]  opc;
  logic [31:0] adr;
  logic [8:0]  cfg;
  logic [13:0] cnt;
  logic [11:0] tmg;
  logic        done;
  logic [7:0]  buf_q [BUF_BYTES];
  logic [3:0]  tcnt;
  logic [16:0] beat, ld_beat;
  logic [2:0]  sub;
  logic [BW-1:0] bidx, nidx;
  logic [31:0] sh, ld_sh;
  logic [7:0]  rx, samp;
  logic [1:0]  a_lg, d_lg, lg;
  logic [3:0]  mask;

  wire busy   = st != IDLE;
  wire wr     = reg_valid && reg_write && !busy;
  wire en_cmd = ctl[7];
  wire en_adr = ctl[6];
  wire en_dum = ctl[8] && cfg[3:0] != 4'd0;
  wire is_wr  = ctl[5];
  wire en_dat = (ctl[5] || ctl[2] || ctl[1]) && cnt != 14'd0;
  wire [2:0] bpb = 3'd7 >> d_lg;

  assign reg_ready = 1'b1;
  assign nidx = BW'(bidx + 1'b1);
  assign a_lg = (cfg[6:4] == 3'd2) ? 2'd1 : (cfg[6:4] == 3'd4) ? 2'd2 : 2'd0;
  assign d_lg = (cfg[6:4] == 3'd1 || cfg[6:4] == 3'd2) ? 2'd1 :
                (cfg[6:4] == 3'd3 || cfg[6:4] == 3'd4) ? 2'd2 : 2'd0;
  assign lg   = (st == ADR) ? a_lg : (st == DAT) ? d_lg : 2'd0;
  assign mask = (lg == 2'd0) ? 4'b0001 : (lg == 2'd1) ? 4'b0011 : 4'b1111;
  assign io_oe  = (st == CMD || st == ADR || (st == DAT && is_wr)) ? mask : 4'b0000;
  assign io_out = (lg == 2'd0) ? {3'b000, sh[31]} : (lg == 2'd1) ? {2'b00, sh[31:30]} : sh[31:28];
  assign cs_n = (st == IDLE || st == DESEL) ? 2'b11 : (cfg[8] ? 2'b01 : 2'b10);
  assign samp = (lg == 2'd0) ? {rx[6:0], io_in[1]} :
                (lg == 2'd1) ? {rx[5:0], io_in[1:0]} : {rx[3:0], io_in};

  always_comb begin
    nxt = HOLD;
    if (st < DAT && en_dat) nxt = DAT;
    if (st < DUM && en_dum) nxt = DUM;
    if (st < ADR && en_adr) nxt = ADR;
    if (st < CMD && en_cmd) nxt = CMD;
  end

  always_comb begin
    ld_sh = sh;
    ld_beat = beat;
    case (nxt)
      CMD: begin ld_sh = {opc, 24'h0}; ld_beat = 17'd7; end
      ADR: begin
        ld_sh = cfg[7] ? adr : {adr[23:0], 8'h0};
        ld_beat = ((cfg[7] ? 17'd32 : 17'd24) >> a_lg) - 17'd1;
      end
      DUM: begin ld_sh = '0; ld_beat = {10'd0, cfg[3:0], 3'd0} - 17'd1; end
      DAT: begin ld_sh = {buf_q[0], 24'h0}; ld_beat = ({cnt, 3'd0} >> d_lg) - 17'd1; end
      default: ;
    endcase
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[7]) reg_rdata = {24'h0, buf_q[reg_addr[BW-1:0]]};
    else case (reg_addr)
      8'h00: reg_rdata = {23'h0, ctl[8:1], busy};
      8'h01: reg_rdata = {24'h0, opc};
      8'h02: reg_rdata = adr;
      8'h03: reg_rdata = {23'h0, cfg};
      8'h04: reg_rdata = {18'h0, cnt};
      8'h05: reg_rdata = {20'h0, tmg};
      8'h06: reg_rdata = {30'h0, busy, done};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ctl <= '0; opc <= '0; adr <= '0; cfg <= '0; cnt <= '0;
      tmg <= 12'h66F; done <= 1'b0; tcnt <= '0; beat <= '0; sub <= '0;
      bidx <= '0; sh <= '0; rx <= '0; sclk <= 1'b0;
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= 8'h0;
    end else begin
      if (reg_valid && reg_write && reg_addr == 8'h06 && reg_wdata[0]) done <= 1'b0;
      if (wr) begin
        if (reg_addr[7]) buf_q[reg_addr[BW-1:0]] <= reg_wdata[7:0];
        else case (reg_addr)
          8'h00: begin
            ctl <= reg_wdata[8:0];
            if (reg_wdata[0]) begin st <= SETUP; tcnt <= tmg[7:4]; end
          end
          8'h01: opc <= reg_wdata[7:0];
          8'h02: adr <= reg_wdata;
          8'h03: cfg <= reg_wdata[8:0];
          8'h04: cnt <= reg_wdata[13:0];
          8'h05: tmg <= reg_wdata[11:0];
          default: ;
        endcase
      end
      case (st)
        SETUP:
          if (tcnt == 4'd0) begin
            st <= nxt; sh <= ld_sh; beat <= ld_beat; sub <= '0; bidx <= '0; tcnt <= tmg[11:8];
          end else tcnt <= tcnt - 4'd1;
        CMD, ADR, DUM, DAT:
          if (!sclk) begin
            sclk <= 1'b1;
            rx <= samp;
          end else begin
            sclk <= 1'b0;
            sh <= sh << (6'd1 << lg);
            if (st == DAT) begin
              if (sub == bpb) begin
                sub <= '0;
                bidx <= nidx;
                if (is_wr) sh <= {buf_q[nidx], 24'h0};
                else buf_q[bidx] <= rx;
              end else sub <= sub + 3'd1;
            end
            if (beat == 17'd0) begin
              st <= nxt; sh <= ld_sh; beat <= ld_beat; sub <= '0; bidx <= '0; tcnt <= tmg[11:8];
            end else beat <= beat - 17'd1;
          end
        HOLD:
          if (tcnt == 4'd0) begin st <= DESEL; tcnt <= tmg[3:0]; end
          else tcnt <= tcnt - 4'd1;
        DESEL:
          if (tcnt == 4'd0) begin st <= IDLE; done <= 1'b1; end
          else tcnt <= tcnt - 4'd1;
        default: ;
      endcase
    end
  end

  logic       any_cs;
  logic [4:0] hi_cnt;
  logic [3:0] last_ds;
  assign any_cs = cs_n != 2'b11;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= 5'd31; last_ds <= '0;
    end else begin
      if (any_cs) hi_cnt <= '0;
      else if (hi_cnt != 5'd31) hi_cnt <= hi_cnt + 5'd1;
      if (st == HOLD && tcnt == 4'd0) last_ds <= tmg[3:0];
    end
  end

  a_r8_deselect_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_cs) |-> hi_cnt > {1'b0, last_ds});
  a_r11_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r11_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == 2'b11) |-> !sclk);
  a_r10_opcode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_valid && reg_write && reg_addr == 8'h01) |=> $stable(opc));
  a_r9_done_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cs_n == 2'b11 && !busy));
endmodule

// File: tb/tb_spi_op_seq.sv
module tb_spi_op_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_ready;
  logic [31:0] reg_rdata;
  logic sclk;
  logic [1:0] cs_n;
  logic [3:0] io_out, io_oe, io_in;

  int total = 0, fails = 0;
  int ecnt = 0;
  int last_cs = -1;
  logic [3:0] rec_out [0:511];
  logic [3:0] rec_oe  [0:511];

  always #(CLK_P/2) clk = ~clk;

  spi_op_seq dut (.clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  function automatic logic [3:0] pat(int k);
    return 4'((k * 5 + 9) ^ (k >> 2));
  endfunction
  assign io_in = pat(ecnt);

  always @(posedge sclk) begin
    if (ecnt < 512) begin rec_out[ecnt] = io_out; rec_oe[ecnt] = io_oe; end
    ecnt = ecnt + 1;
  end
  always @(negedge cs_n[0]) begin ecnt = 0; last_cs = 0; end
  always @(negedge cs_n[1]) begin ecnt = 0; last_cs = 1; end

  int cnt_s = 0, cnt_h = 0, m_setup = 0, m_hold = 0;
  bit seen = 0, was_low = 0;
  always @(negedge clk) begin
    if (cs_n == 2'b11) begin
      if (was_low) m_hold = cnt_h;
      cnt_s = 0; cnt_h = 0; seen = 0; was_low = 0;
    end else begin
      was_low = 1;
      if (!seen) begin
        if (sclk) begin seen = 1; m_setup = cnt_s; end else cnt_s++;
      end
      if (sclk) cnt_h = 0; else cnt_h++;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    total++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic setup_op(input logic [7:0] op, input logic [31:0] ad,
                          input logic [8:0] cf, input logic [13:0] n);
    wr(8'h01, {24'h0, op}); wr(8'h02, ad); wr(8'h03, {23'h0, cf}); wr(8'h04, {18'h0, n});
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] s;
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h06, s);
      if (s[0]) begin ok = 1; break; end
    end
  endtask

  task automatic go(input logic [8:0] c, output bit ok);
    wr(8'h00, {23'h0, c});
    wait_done(ok);
    wr(8'h06, 32'h1);
  endtask

  function automatic logic [31:0] got(int s, int n, int lg);
    logic [31:0] v = '0;
    for (int e = 0; e < n; e++)
      case (lg)
        0: v = {v[30:0], rec_out[s+e][0]};
        1: v = {v[29:0], rec_out[s+e][1:0]};
        default: v = {v[27:0], rec_out[s+e]};
      endcase
    return v;
  endfunction

  function automatic logic [7:0] exp_rd(int s, int j, int lg);
    logic [7:0] v = '0;
    int per = 8 >> lg;
    for (int e = 0; e < per; e++) begin
      logic [3:0] p = pat(s + j * per + e);
      case (lg)
        0: v = {v[6:0], p[1]};
        1: v = {v[5:0], p[1:0]};
        default: v = {v[3:0], p};
      endcase
    end
    return v;
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 cs_n", cs_n, 2'b11);
    chk("R1 sclk", sclk, 0);
    chk("R1 io_oe", io_oe, 0);
    rd(8'h06, d); chk("R1 status", d, 0);
    rd(8'h05, d); chk("R1 R8 timing default", d, 32'h66F);
  endtask

  task automatic t_cmd_only;
    bit ok; logic [31:0] d;
    setup_op(8'h9F, 32'h0, 9'h000, 14'd0);
    go(9'h081, ok);
    chk("R9 done seen", ok, 1);
    chk("R3 edge count", ecnt, 8);
    chk("R3 opcode bits", got(0, 8, 0), 32'h9F);
    chk("R3 oe single lane", rec_oe[0], 4'b0001);
    chk("R11 cs0 used", last_cs, 0);
    rd(8'h06, d); chk("R9 cleared", d[0], 0);
  endtask

  task automatic t_read_single;
    bit ok; logic [31:0] d;
    setup_op(8'h03, 32'hFF123456, 9'h000, 14'd2);
    go(9'h0C5, ok);
    chk("R2 R4 edge count", ecnt, 48);
    chk("R4 three-byte address", got(8, 24, 0), 32'h123456);
    chk("R5 read lanes released", rec_oe[32], 0);
    rd(8'h80, d); chk("R7 read byte0", d, exp_rd(32, 0, 0));
    rd(8'h81, d); chk("R7 read byte1", d, exp_rd(32, 1, 0));
  endtask

  task automatic t_quad_io;
    bit ok; logic [31:0] d;
    setup_op(8'hEB, 32'hA1B2C3D4, 9'h1C1, 14'd3);
    go(9'h1C5, ok);
    chk("R2 R6 edge count", ecnt, 30);
    chk("R4 R5 four-byte quad address", got(8, 8, 2), 32'hA1B2C3D4);
    chk("R5 quad addr oe", rec_oe[8], 4'b1111);
    chk("R6 dummy lanes off", rec_oe[16], 0);
    chk("R11 cs1 used", last_cs, 1);
    for (int j = 0; j < 3; j++) begin
      rd(8'(8'h80 + j), d); chk("R5 R7 quad read byte", d, exp_rd(24, j, 2));
    end
  endtask

  task automatic t_status_quad_out;
    bit ok; logic [31:0] d;
    setup_op(8'h05, 32'h0, 9'h030, 14'd1);
    go(9'h083, ok);
    chk("R2 R5 status read edges", ecnt, 10);
    rd(8'h80, d); chk("R2 R5 status byte", d, exp_rd(8, 0, 2));
  endtask

  task automatic t_write_dual;
    bit ok;
    wr(8'h80, 32'h5A); wr(8'h81, 32'hC3);
    setup_op(8'h02, 32'h00ABCDEF, 9'h020, 14'd2);
    go(9'h0E5, ok);
    chk("R2 R5 dual write edges", ecnt, 28);
    chk("R3 cmd still single", rec_oe[0], 4'b0001);
    chk("R5 dual address", got(8, 12, 1), 32'hABCDEF);
    chk("R7 write byte0", got(20, 4, 1), 32'h5A);
    chk("R7 write byte1", got(24, 4, 1), 32'hC3);
    chk("R5 dual write oe", rec_oe[20], 4'b0011);
  endtask

  task automatic t_zero_count;
    bit ok; logic [31:0] d;
    wr(8'h80, 32'h77);
    setup_op(8'h03, 32'h0, 9'h000, 14'd0);
    go(9'h085, ok);
    chk("R7 zero count edges", ecnt, 8);
    rd(8'h80, d); chk("R7 zero count buffer kept", d, 32'h77);
  endtask

  task automatic t_busy_ignore;
    bit ok; logic [31:0] d;
    setup_op(8'h0B, 32'h0, 9'h000, 14'd4);
    wr(8'h00, 32'h085);
    wr(8'h01, 32'h11);
    wr(8'h83, 32'hEE);
    wr(8'h00, 32'h081);
    wait_done(ok);
    wr(8'h06, 32'h1);
    chk("R10 edges of first op", ecnt, 40);
    chk("R10 opcode on wire", got(0, 8, 0), 32'h0B);
    rd(8'h01, d); chk("R10 opcode register", d, 32'h0B);
    rd(8'h83, d); chk("R10 buffer write dropped", d, exp_rd(8, 3, 0));
    repeat (60) @(negedge clk);
    chk("R10 no second op", cs_n, 2'b11);
    chk("R10 edges unchanged", ecnt, 40);
  endtask

  task automatic t_timing;
    bit ok; int n;
    logic [31:0] s;
    wr(8'h05, 32'h359);
    setup_op(8'h06, 32'h0, 9'h000, 14'd0);
    wr(8'h00, 32'h081);
    wait (cs_n != 2'b11);
    wait (cs_n == 2'b11);
    n = 0; ok = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); n++;
      reg_addr = 8'h06; #1 s = reg_rdata;
      if (s[0]) begin ok = 1; break; end
    end
    wr(8'h06, 32'h1);
    chk_rng("R8 setup time", m_setup, 5, 8);
    chk_rng("R8 hold time", m_hold, 3, 5);
    chk_rng("R8 R9 deselect before done", n, 10, 12);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd_only();
    t_read_single();
    t_quad_io();
    t_status_quad_out();
    t_write_dual();
    t_zero_count();
    t_busy_ignore();
    t_timing();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule